// File: doc/BRIEF.md
# Manchester Line Transmitter for 10 Mbit/s Twisted-Pair Ethernet

This block turns a byte stream into the line signal of a 10 Mbit/s twisted-pair link. The caller hands over one frame as bytes on a valid/ready port and marks the final byte. The frame check bytes are already appended by the caller, because this block does not compute them. The transmitter first sends its own preamble and start-of-frame delimiter and then the caller's bytes, least significant bit first. It drives a pair of complementary outputs with Manchester symbols, each made by XORing the NRZ bit with a bit-rate clock that is aligned to the cell boundaries.

Between frames the encoder is switched out of the path, so both wires sit low. This is a state that a pure Manchester stream cannot reach. After every frame the block keeps the line quiet for the inter-frame gap before it accepts another frame. When there has been no traffic for a programmable number of clocks, it emits a single link pulse one bit time wide, also with the encoder bypassed. Everything runs from one fast clock. A divider produces the half-bit timing, so `HALF_CYC` clock cycles make one 50 ns half-bit. The default of 4 suits an 80 MHz clock.

Top module: `mtx_eth_tx`

## Requirements
- R1: Every half-bit symbol on the pair lasts exactly `HALF_CYC` clock cycles, and the outputs change only at half-bit boundaries.
- R2: While a frame is on the line, `line_neg` is always the inverse of `line_pos`. The two outputs are never high together.
- R3: With `ONE_RISES`=1, a data 1 is sent with `line_pos` low in the first half and high in the second, and a data 0 is sent high then low. Each byte is sent bit 0 first.
- R4: A frame on the line is `PREAMBLE_BYTES` bytes of 0x55, then one 0xD5, then every accepted byte in order, up to and including the byte marked by `in_last`. Frames of 1526 bytes on the wire are carried whole.
- R5: Out of reset and whenever no frame or link pulse is being sent, both outputs are low.
- R6: `in_ready` is high only when the block is idle with no link pulse pending, or during the payload while its one-byte holding register is empty and the final byte has not yet been taken. It is low during the preamble, the gap and link pulses.
- R7: After the last bit of a frame, the line stays quiet for at least `GAP_BITS` bit times (2·`GAP_BITS`·`HALF_CYC` cycles) before the next frame starts.
- R8: After `LINK_CYC` clock cycles of idle, `line_pos` goes high and `line_neg` stays low for exactly 2·`HALF_CYC` cycles. Consecutive pulses on an idle line start 2·`HALF_CYC` + ⌈(`LINK_CYC`+1)/`HALF_CYC`⌉·`HALF_CYC` cycles apart. A pulse never starts during a frame or its gap, and the first pulse after a frame comes no earlier than gap plus `LINK_CYC`.
- R9: If a byte boundary inside the payload is reached with no byte held and the current byte not marked last, `underrun` pulses for one cycle, the line goes quiet at that boundary and the gap is enforced.

Parameter guidance: `HALF_CYC` is clock cycles per half-bit, `GAP_BITS` is the gap length in bit times, `LINK_CYC` is the idle clocks before a link pulse, `PREAMBLE_BYTES` is the number of 0x55 bytes, and `ONE_RISES` selects the symbol polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, `HALF_CYC` cycles per half-bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Caller offers a byte |
| in_data | input | 8 | Offered byte |
| in_last | input | 1 | Offered byte is the final byte of the frame |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| line_pos | output | 1 | Positive wire of the pair |
| line_neg | output | 1 | Negative wire of the pair |
| underrun | output | 1 | One-cycle pulse when the caller failed to supply a payload byte in time |

## Verification
The assertions assume the caller keeps `in_data` and `in_last` steady while `in_valid` waits for `in_ready`. They also assume `in_last` is set only on a byte the caller really means to end the frame with. The bench drives its inputs only at the falling edge, holds each byte until a handshake has been seen, and drops `in_valid` after the final byte. Underrun is provoked only on purpose, by withholding a byte from a frame whose only byte is not marked last. Gaps between bench scenarios stay well below `LINK_CYC`, so a link pulse can appear only in the scenario built to observe one.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_PRE,
      ST_DATA,
      ST_GAP,
      ST_LINK
   } mtx_state_e;

   typedef enum logic [1:0] {
      LN_QUIET,
      LN_ENCODE,
      LN_PULSE
   } mtx_line_e;

   localparam logic [7:0] MTX_PRE_BYTE = 8'h55;
   localparam logic [7:0] MTX_SFD_BYTE = 8'hD5;
   localparam int unsigned MTX_BYTE_BITS = 8;

endpackage

// File: rtl/mtx_halfbit_div.sv
module mtx_halfbit_div #(
   parameter int unsigned HALF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   generate
      if (HALF_CYC == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         logic          at_end;

         assign at_end = (cnt_q == CW'(HALF_CYC - 1));
         assign tick   = at_end;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (at_end) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mtx_link_timer.sv
module mtx_link_timer #(
   parameter int unsigned LINK_CYC = 1280000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic due
);
   localparam int unsigned CW = $clog2(LINK_CYC + 1);

   logic [CW-1:0] cnt_q;
   logic          full;

   assign full = (cnt_q == CW'(LINK_CYC));
   assign due  = full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (!full) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/mtx_line_drive.sv
module mtx_line_drive
   import mtx_pkg::*;
#(
   parameter bit ONE_RISES = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  mtx_line_e mode,
   input  logic      bit_i,
   input  logic      second_half,
   output logic      line_pos,
   output logic      line_neg
);
   logic enc;
   logic pos_d, neg_d;

   // bit-rate clock is high in the first half of each cell
   generate
      if (ONE_RISES) begin : g_rise_one
         assign enc = bit_i ^ ~second_half;
      end else begin : g_fall_one
         assign enc = bit_i ^ second_half;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         LN_ENCODE: begin
            pos_d = enc;
            neg_d = ~enc;
         end
         LN_PULSE: begin
            pos_d = 1'b1;
            neg_d = 1'b0;
         end
         default: begin
            pos_d = 1'b0;
            neg_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_pos <= 1'b0;
         line_neg <= 1'b0;
      end else begin
         line_pos <= pos_d;
         line_neg <= neg_d;
      end
   end

endmodule

// File: rtl/mtx_eth_tx.sv
module mtx_eth_tx
   import mtx_pkg::*;
#(
   parameter int unsigned HALF_CYC       = 4,
   parameter int unsigned GAP_BITS       = 96,
   parameter int unsigned LINK_CYC       = 1280000,
   parameter int unsigned PREAMBLE_BYTES = 7,
   parameter bit          ONE_RISES      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   input  logic       in_last,
   output logic       in_ready,
   output logic       line_pos,
   output logic       line_neg,
   output logic       underrun
);
   localparam int unsigned GAP_HALVES = 2 * GAP_BITS;
   localparam int unsigned GW         = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
   localparam int unsigned PW         = $clog2(PREAMBLE_BYTES + 1);
   localparam int unsigned BW         = $clog2(MTX_BYTE_BITS);

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
      if (GAP_BITS < 1) begin : g_bad_gap
         $error("GAP_BITS must be at least 1");
      end
      if (PREAMBLE_BYTES < 1) begin : g_bad_pre
         $error("PREAMBLE_BYTES must be at least 1");
      end
      if (LINK_CYC < 4) begin : g_bad_link
         $error("LINK_CYC must be at least 4");
      end
   endgenerate

   mtx_state_e     state_q;
   logic           half_q;
   logic [7:0]     sh_q;
   logic [BW-1:0]  bitn_q;
   logic [PW-1:0]  pre_idx_q;
   logic           cur_last_q;
   logic [7:0]     hold_q;
   logic           hold_full_q;
   logic           hold_last_q;
   logic [GW-1:0]  gap_cnt_q;
   logic           underrun_q;

   logic           tick;
   logic           link_due;
   logic           accept;
   logic           byte_end;
   mtx_line_e      line_mode;

   mtx_halfbit_div #(
      .HALF_CYC(HALF_CYC)
   ) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   mtx_link_timer #(
      .LINK_CYC(LINK_CYC)
   ) u_link (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state_q == ST_IDLE),
      .due  (link_due)
   );

   assign in_ready = ((state_q == ST_IDLE) && !link_due) ||
                     ((state_q == ST_DATA) && !hold_full_q && !cur_last_q);
   assign accept   = in_valid && in_ready;
   assign byte_end = tick && half_q && (bitn_q == BW'(MTX_BYTE_BITS - 1));
   assign underrun = underrun_q;

   always_comb begin
      unique case (state_q)
         ST_PRE, ST_DATA: line_mode = LN_ENCODE;
         ST_LINK:         line_mode = LN_PULSE;
         default:         line_mode = LN_QUIET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         half_q      <= 1'b0;
         sh_q        <= '0;
         bitn_q      <= '0;
         pre_idx_q   <= '0;
         cur_last_q  <= 1'b0;
         hold_q      <= '0;
         hold_full_q <= 1'b0;
         hold_last_q <= 1'b0;
         gap_cnt_q   <= '0;
         underrun_q  <= 1'b0;
      end else begin
         underrun_q <= 1'b0;

         if (accept) begin
            hold_q      <= in_data;
            hold_full_q <= 1'b1;
            hold_last_q <= in_last;
         end

         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_ARM;
               end else if (tick && link_due) begin
                  state_q <= ST_LINK;
                  half_q  <= 1'b0;
               end
            end

            ST_ARM: begin
               if (tick) begin
                  state_q    <= ST_PRE;
                  half_q     <= 1'b0;
                  sh_q       <= (PREAMBLE_BYTES == 0) ? MTX_SFD_BYTE : MTX_PRE_BYTE;
                  bitn_q     <= '0;
                  pre_idx_q  <= '0;
                  cur_last_q <= 1'b0;
               end
            end

            ST_PRE, ST_DATA: begin
               if (tick) begin
                  half_q <= ~half_q;
                  if (half_q && !byte_end) begin
                     sh_q   <= sh_q >> 1;
                     bitn_q <= bitn_q + 1'b1;
                  end
                  if (byte_end) begin
                     bitn_q <= '0;
                     if (state_q == ST_PRE) begin
                        if (pre_idx_q == PW'(PREAMBLE_BYTES)) begin
                           sh_q        <= hold_q;
                           cur_last_q  <= hold_last_q;
                           hold_full_q <= 1'b0;
                           state_q     <= ST_DATA;
                        end else begin
                           pre_idx_q <= pre_idx_q + 1'b1;
                           sh_q      <= (pre_idx_q == PW'(PREAMBLE_BYTES - 1)) ?
                                        MTX_SFD_BYTE : MTX_PRE_BYTE;
                        end
                     end else if (cur_last_q) begin
                        state_q   <= ST_GAP;
                        gap_cnt_q <= '0;
                     end else if (hold_full_q) begin
                        sh_q        <= hold_q;
                        cur_last_q  <= hold_last_q;
                        hold_full_q <= 1'b0;
                     end else begin
                        underrun_q <= 1'b1;
                        state_q    <= ST_GAP;
                        gap_cnt_q  <= '0;
                     end
                  end
               end
            end

            ST_GAP: begin
               if (tick) begin
                  if (gap_cnt_q == GW'(GAP_HALVES - 1)) begin
                     state_q <= ST_IDLE;
                  end else begin
                     gap_cnt_q <= gap_cnt_q + 1'b1;
                  end
               end
            end

            ST_LINK: begin
               if (tick) begin
                  if (half_q) begin
                     half_q  <= 1'b0;
                     state_q <= ST_IDLE;
                  end else begin
                     half_q <= 1'b1;
                  end
               end
            end

            default: state_q <= ST_IDLE;
         endcase
      end
   end

   mtx_line_drive #(
      .ONE_RISES(ONE_RISES)
   ) u_drive (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (line_mode),
      .bit_i      (sh_q[0]),
      .second_half(half_q),
      .line_pos   (line_pos),
      .line_neg   (line_neg)
   );

endmodule

// File: rtl/mtx_eth_tx_chk.sv
module mtx_eth_tx_chk
   import mtx_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input mtx_state_e state,
   input mtx_line_e  line_mode,
   input logic       in_ready,
   input logic       line_pos,
   input logic       line_neg,
   input logic       underrun
);

   AST_HALF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick, 2) |-> $stable({line_pos, line_neg})); // R1

   AST_NEVER_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_pos && line_neg)); // R2

   AST_ENC_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (line_mode == LN_ENCODE) |=> (line_pos != line_neg)); // R2

   AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (line_mode == LN_QUIET) |=> (!line_pos && !line_neg)); // R5

   AST_READY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> ((state == ST_IDLE) || (state == ST_DATA))); // R6

   AST_LINK_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LINK) |-> (($past(state) == ST_IDLE) || ($past(state) == ST_LINK))); // R8

   AST_PULSE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (line_mode == LN_PULSE) |=> (line_pos && !line_neg)); // R8

   AST_UNDERRUN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> (($past(state) == ST_DATA) && (state == ST_GAP))); // R9

endmodule

bind mtx_eth_tx mtx_eth_tx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .state    (state_q),
   .line_mode(line_mode),
   .in_ready (in_ready),
   .line_pos (line_pos),
   .line_neg (line_neg),
   .underrun (underrun)
);

// File: tb/mtx_eth_tx_tb_top.sv
`timescale 1ns/1ps
module mtx_eth_tx_tb_top;
   localparam int H  = 2;
   localparam int GB = 96;
   localparam int LC = 3000;
   localparam int PB = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_last = 1'b0;
   logic       in_ready;
   logic       line_pos;
   logic       line_neg;
   logic       underrun;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int und_cnt = 0;
   int last_end = 0;
   int rx_n = 0;

   logic [7:0] mem [0:2047];
   bit         rxb [0:16383];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (underrun) und_cnt <= und_cnt + 1;

   mtx_eth_tx #(
      .HALF_CYC(H), .GAP_BITS(GB), .LINK_CYC(LC),
      .PREAMBLE_BYTES(PB), .ONE_RISES(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_ready(in_ready), .line_pos(line_pos),
      .line_neg(line_neg), .underrun(underrun)
   );

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(int off, int len, bit end_flag);
      bit hs;
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b1;
         in_data  = mem[off + i];
         in_last  = end_flag && (i == len - 1);
         do begin
            hs = in_ready;
            @(negedge clk);
         end while (!hs);
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic rx_frame(output int s, output int e, output int shape,
                           output int comp, output bit rdy_pre, output bit rdy_gap);
      bit a, b;
      shape = 0; comp = 0; rx_n = 0;
      while (!(line_pos ^ line_neg)) @(negedge clk);
      s = cyc;
      rdy_pre = in_ready;
      forever begin
         if (!line_pos && !line_neg) break;
         a = line_pos;
         if (line_neg == a) comp++;
         repeat (H - 1) begin
            @(negedge clk);
            if (line_pos != a) shape++;
         end
         @(negedge clk);
         b = line_pos;
         if (line_neg == b) begin comp++; shape++; end
         repeat (H - 1) begin
            @(negedge clk);
            if (line_pos != b) shape++;
         end
         @(negedge clk);
         if (a == b) shape++;
         if (rx_n < 16384) begin
            rxb[rx_n] = b;
            rx_n++;
         end
      end
      e = cyc;
      rdy_gap = in_ready;
   endtask

   task automatic cmp_frame(int off, int len);
      int nbytes;
      int bad_k;
      logic [7:0] got, expv, bad_got, bad_exp;
      nbytes = PB + 1 + len;
      check(rx_n == nbytes * 8, "R4", "bits on the wire", rx_n, nbytes * 8);
      bad_k = -1; bad_got = '0; bad_exp = '0;
      for (int k = 0; k < nbytes && (k + 1) * 8 <= rx_n; k++) begin
         for (int j = 0; j < 8; j++) got[j] = rxb[k * 8 + j];
         expv = (k < PB) ? 8'h55 : (k == PB) ? 8'hD5 : mem[off + k - PB - 1];
         if (got != expv && bad_k < 0) begin
            bad_k = k; bad_got = got; bad_exp = expv;
         end
      end
      check(bad_k < 0, "R4 R3", "byte value (LSB-first decode)", bad_got, bad_exp);
   endtask

   task automatic frame_checks(int shape, int comp, bit rp, bit rg, int u0);
      check(shape == 0, "R1 R3", "half-bit shape errors", shape, 0);
      check(comp == 0, "R2", "non-complementary halves", comp, 0);
      check(rp == 1'b0, "R6", "in_ready during preamble", rp, 0);
      check(rg == 1'b0, "R6", "in_ready during gap", rg, 0);
      check(und_cnt == u0, "R9", "spurious underrun pulses", und_cnt - u0, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!line_pos && !line_neg, "R5", "line after reset", {line_pos, line_neg}, 0);
      check(in_ready == 1'b1, "R6", "in_ready idle after reset", in_ready, 1);
      check(underrun == 1'b0, "R9", "underrun after reset", underrun, 0);
   endtask

   task automatic t_frame(int len, int kind);
      int s, e, sh, cp, u0;
      bit rp, rg;
      for (int i = 0; i < len; i++) begin
         case (kind)
            0: mem[i] = 8'((i * 37 + 5) & 255);
            1: mem[i] = 8'h00;
            2: mem[i] = 8'hFF;
            default: mem[i] = (i % 2 == 0) ? 8'hD5 : 8'h55;
         endcase
      end
      u0 = und_cnt;
      fork
         drive(0, len, 1'b1);
         rx_frame(s, e, sh, cp, rp, rg);
      join
      cmp_frame(0, len);
      frame_checks(sh, cp, rp, rg, u0);
      last_end = e;
   endtask

   task automatic t_back_to_back();
      int sa, ea, sb, eb, sh, cp, u0;
      bit rp, rg;
      for (int i = 0; i < 22; i++) mem[i] = 8'((i * 11 + 3) & 255);
      u0 = und_cnt;
      fork
         begin
            drive(0, 10, 1'b1);
            drive(10, 12, 1'b1);
         end
         begin
            rx_frame(sa, ea, sh, cp, rp, rg);
            cmp_frame(0, 10);
            frame_checks(sh, cp, rp, rg, u0);
            rx_frame(sb, eb, sh, cp, rp, rg);
            cmp_frame(10, 12);
            frame_checks(sh, cp, rp, rg, u0);
         end
      join
      check(sb - ea >= 2 * GB * H, "R7", "quiet cycles between frames", sb - ea, 2 * GB * H);
      last_end = eb;
   endtask

   task automatic t_underrun();
      int s, e, sh, cp, u0;
      bit rp, rg;
      mem[0] = 8'h3C;
      u0 = und_cnt;
      fork
         drive(0, 1, 1'b0);
         rx_frame(s, e, sh, cp, rp, rg);
      join
      cmp_frame(0, 1);
      check(und_cnt - u0 == 1, "R9", "underrun pulses", und_cnt - u0, 1);
      check(sh == 0, "R9", "shape of aborted frame", sh, 0);
      check(rg == 1'b0, "R9", "in_ready in gap after underrun", rg, 0);
      repeat (2 * H) @(negedge clk);
      check(!line_pos && !line_neg, "R9", "line quiet after underrun", {line_pos, line_neg}, 0);
      last_end = e;
   endtask

   task automatic t_link();
      int t1, t2, w, rdy;
      t_frame(3, 0);
      while (!(line_pos && !line_neg)) @(negedge clk);
      t1 = cyc;
      rdy = in_ready;
      w = 0;
      while (line_pos) begin
         w++;
         @(negedge clk);
      end
      check(!line_neg, "R5", "line quiet after link pulse", line_neg, 0);
      while (!(line_pos && !line_neg)) @(negedge clk);
      t2 = cyc;
      check(w == 2 * H, "R8", "link pulse width", w, 2 * H);
      check(rdy == 0, "R6", "in_ready during link pulse", rdy, 0);
      check(t1 - last_end >= 2 * GB * H + LC, "R8", "first pulse after frame", t1 - last_end,
            2 * GB * H + LC);
      check(t2 - t1 == 2 * H + ((LC + H) / H) * H, "R8", "link pulse spacing", t2 - t1,
            2 * H + ((LC + H) / H) * H);
      while (line_pos) @(negedge clk);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 200000);
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_frame(1, 0);
      t_frame(16, 0);
      t_frame(5, 1);
      t_frame(9, 2);
      t_frame(6, 3);
      t_back_to_back();
      t_underrun();
      t_frame(1518, 0);
      t_link();
      summary();
      $finish;
   end

endmodule